// File: doc/BRIEF.md
# Clock-Synchronous Serial Transceiver

This block is a byte-wide serial port that moves data over a shared shift clock, with no start, stop or parity bits. It holds a transmit holding register and a receive holding register, and it reports three conditions: transmit holding register empty, receive byte ready, and receive overrun. A host writes a byte to send. When the byte has been shifted in from the serial input, the host reads it back. Interrupt requests for "receive ready" and "transmit empty" are each gated by their own enable.

The shift clock can come from either side. In internal mode, the block makes the clock itself from a single-cycle `tick` enable, and a byte written to the transmit register starts a transfer. In external mode, the block drives no clock. It follows a clock supplied by a partner device, through a two-stage synchronizer and edge detection in the system clock domain. In both modes the output bit changes after a falling clock edge and the input bit is sampled on a rising edge. Both lines rest high between transfers.

Top module: `sync_shift_port`

## Requirements
- R1: A transfer carries exactly 8 data bits, least significant bit first, with no framing bits. The serial output changes after each falling shift clock edge, and the serial input is sampled at each rising edge.
- R2: In internal mode one transfer produces exactly 8 low pulses on `sck_out`, one per `tick` pair: the first tick makes a falling edge and the second makes a rising edge.
- R3: `sout` and `sck_out` stay high (mark level) before a transfer starts and return high after it ends.
- R4: In internal mode a transfer starts once the transmit register holds a byte and `tx_en` or `rx_en` is set. That byte is then consumed. With `tx_en` low, `sout` stays high for the whole byte while reception still runs.
- R5: In external mode `sck_oe` is 0 and a transfer starts on the first falling edge of `sck_in`. If `tx_en` is low or no byte is pending, `sout` stays high for all 8 bits.
- R6: `tx_empty` reads 0 while a written byte waits. It reads 1 once that byte has moved into the shifter. A pending byte is not consumed by an external transfer while `tx_en` is low.
- R7: `rx_full` goes to 1 when the eighth bit is sampled, with the byte on `rd_data`. A one-cycle `rd_en` pulse clears `rx_full`.
- R8: When a byte completes while `rx_full` is 1 and no read arrives in that cycle, `overrun` goes to 1 and `rd_data` keeps the earlier byte. When a read and a completion coincide, the new byte is stored, `rx_full` stays 1 and no overrun is flagged.
- R9: Holding `clr_err_n` at 0 for a cycle clears `overrun`.
- R10: `irq_rx` equals `rx_ie` AND `rx_full`, and `irq_tx` equals `tx_ie` AND `tx_empty`.
- R11: `sout_oe` follows `sout_en`. When it is 0, the line is released and reads high.
- R12: With `rx_en` low, a completed transfer changes neither `rd_data`, `rx_full` nor `overrun`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | Internal shift clock half-period enable |
| int_clk | input | 1 | 1 = internal clock source, 0 = external |
| tx_en | input | 1 | Transmit enable |
| rx_en | input | 1 | Receive enable |
| sout_en | input | 1 | Serial output drive enable |
| tx_ie | input | 1 | Transmit-empty interrupt enable |
| rx_ie | input | 1 | Receive-ready interrupt enable |
| clr_err_n | input | 1 | Active-low error clear |
| wr_en | input | 1 | Write strobe for the transmit register |
| wr_data | input | DW | Byte to transmit |
| rd_en | input | 1 | Read strobe for the receive register |
| rd_data | output | DW | Received byte |
| tx_empty | output | 1 | Transmit register empty |
| rx_full | output | 1 | Receive byte ready |
| overrun | output | 1 | Receive overrun error |
| irq_tx | output | 1 | Transmit interrupt request |
| irq_rx | output | 1 | Receive interrupt request |
| sin | input | 1 | Serial data input |
| sck_in | input | 1 | External shift clock |
| sck_out | output | 1 | Internally generated shift clock |
| sck_oe | output | 1 | Shift clock drive enable |
| sout | output | 1 | Serial data output |
| sout_oe | output | 1 | Serial data output enable |

## Verification
A host read of the receive register and the sampling of the eighth bit of a new byte can land in the same cycle. In that case the read must win the clear, and the new byte must be stored without an overrun. The bench drives the internal clock itself, so it knows which `tick` produces the final rising edge. It raises `rd_en` in exactly that cycle while a previous byte is still unread. It then expects `rx_full` at 1, `overrun` at 0 and the new byte on `rd_data`. It checks the result against a transfer that completes with no read, where the overrun flag must rise and the old byte must stay.

// File: rtl/ssp_pkg.sv
package ssp_pkg;

    typedef enum logic {
        CLK_EXT = 1'b0,
        CLK_INT = 1'b1
    } clk_src_e;

    typedef struct packed {
        logic fall;
        logic rise;
    } sck_edge_t;

endpackage

// File: rtl/ssp_sync.sv
module ssp_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    logic [STAGES-1:0][WIDTH-1:0] stg_d, stg_q;

    always_comb begin
        stg_d[0] = d;
        for (int i = 1; i < STAGES; i++) begin
            stg_d[i] = stg_q[i-1];
        end
    end

    // Lines idle high, so the chain resets to the mark level.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg_q <= '1;
        else        stg_q <= stg_d;
    end

    assign q = stg_q[STAGES-1];

endmodule

// File: rtl/ssp_clkgen.sv
module ssp_clkgen
    import ssp_pkg::*;
#(
    parameter int BITS = 8
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      start,
    input  logic      tick,
    output logic      sck,
    output sck_edge_t ev
);

    localparam int EDGES = 2 * BITS;
    localparam int PW    = $clog2(EDGES);

    typedef struct packed {
        logic          run;
        logic          sck;
        logic [PW-1:0] ph;
    } cg_t;

    cg_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        ev.fall = st_q.run & tick & st_q.sck;
        ev.rise = st_q.run & tick & ~st_q.sck;
        if (st_q.run && tick) begin
            st_d.sck = ~st_q.sck;
            st_d.ph  = st_q.ph + 1'b1;
            if (st_q.ph == PW'(EDGES - 1)) begin
                st_d.run = 1'b0;
                st_d.ph  = '0;
            end
        end else if (start && !st_q.run) begin
            st_d.run = 1'b1;
            st_d.ph  = '0;
            st_d.sck = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{run: 1'b0, sck: 1'b1, ph: '0};
        else        st_q <= st_d;
    end

    assign sck = st_q.sck;

    // R3: clock rests high whenever no transfer is running
    p_clk_idle_high_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !st_q.run |-> st_q.sck);

    // R2: a run ends only after the full count of edges
    p_edge_count_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(st_q.run) |-> ($past(st_q.ph) == PW'(EDGES - 1)) && st_q.sck);

endmodule

// File: rtl/sync_shift_port.sv
module sync_shift_port
    import ssp_pkg::*;
#(
    parameter int DW          = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          int_clk,
    input  logic          tx_en,
    input  logic          rx_en,
    input  logic          sout_en,
    input  logic          tx_ie,
    input  logic          rx_ie,
    input  logic          clr_err_n,
    input  logic          wr_en,
    input  logic [DW-1:0] wr_data,
    input  logic          rd_en,
    output logic [DW-1:0] rd_data,
    output logic          tx_empty,
    output logic          rx_full,
    output logic          overrun,
    output logic          irq_tx,
    output logic          irq_rx,
    input  logic          sin,
    input  logic          sck_in,
    output logic          sck_out,
    output logic          sck_oe,
    output logic          sout,
    output logic          sout_oe
);

    localparam int CW = $clog2(DW);

    typedef struct packed {
        logic [DW-1:0] tdr;
        logic          tdr_full;
        logic [DW-1:0] txsh;
        logic [DW-1:0] rxsh;
        logic [DW-1:0] rdr;
        logic          rx_full;
        logic          ovr;
        logic          busy;
        logic [CW-1:0] cnt;
        logic          sout;
        logic          rxact;
        logic          sck_prv;
    } core_t;

    core_t st_d, st_q;

    logic      use_int;
    logic [1:0] sync_q;
    logic      sin_s, sck_s;
    logic      ext_fall, ext_rise;
    logic      start_int, start_ext;
    logic      ev_fall, ev_rise;
    logic      done;
    logic      cg_sck;
    sck_edge_t cg_ev;
    logic [DW-1:0] load_val, rx_next;

    assign use_int = (clk_src_e'(int_clk) == CLK_INT);

    ssp_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({sck_in, sin}),
        .q     (sync_q)
    );

    assign sck_s    = sync_q[1];
    assign sin_s    = sync_q[0];
    assign ext_fall = st_q.sck_prv & ~sck_s;
    assign ext_rise = ~st_q.sck_prv & sck_s;

    assign start_int = use_int & ~st_q.busy & st_q.tdr_full & (tx_en | rx_en);
    assign start_ext = ~use_int & ~st_q.busy & ext_fall & (tx_en | rx_en);

    ssp_clkgen #(.BITS(DW)) u_clkgen (
        .clk   (clk),
        .rst_n (rst_n),
        .start (start_int),
        .tick  (tick),
        .sck   (cg_sck),
        .ev    (cg_ev)
    );

    assign ev_fall  = use_int ? cg_ev.fall : ext_fall;
    assign ev_rise  = use_int ? cg_ev.rise : ext_rise;
    assign load_val = (tx_en & st_q.tdr_full) ? st_q.tdr : '1;
    assign rx_next  = {sin_s, st_q.rxsh[DW-1:1]};

    always_comb begin
        st_d         = st_q;
        done         = 1'b0;
        st_d.sck_prv = sck_s;

        if (start_int || start_ext) begin
            st_d.busy  = 1'b1;
            st_d.cnt   = '0;
            st_d.txsh  = load_val;
            st_d.rxact = rx_en;
            if (st_q.tdr_full && (tx_en || use_int)) st_d.tdr_full = 1'b0;
            // external start is itself the first falling edge
            if (start_ext) st_d.sout = load_val[0];
        end else if (st_q.busy) begin
            if (ev_fall) st_d.sout = st_q.txsh[0];
            if (ev_rise) begin
                st_d.rxsh = rx_next;
                st_d.txsh = {1'b1, st_q.txsh[DW-1:1]};
                st_d.cnt  = st_q.cnt + 1'b1;
                if (st_q.cnt == CW'(DW - 1)) begin
                    st_d.busy = 1'b0;
                    st_d.sout = 1'b1;
                    st_d.cnt  = '0;
                    done      = st_q.rxact;
                end
            end
        end

        if (rd_en) st_d.rx_full = 1'b0;
        if (done) begin
            if (st_q.rx_full && !rd_en) begin
                st_d.ovr = 1'b1;
            end else begin
                st_d.rdr     = rx_next;
                st_d.rx_full = 1'b1;
            end
        end
        if (!clr_err_n) st_d.ovr = 1'b0;

        if (wr_en) begin
            st_d.tdr      = wr_data;
            st_d.tdr_full = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{tdr: '0, tdr_full: 1'b0, txsh: '1, rxsh: '1, rdr: '0,
                      rx_full: 1'b0, ovr: 1'b0, busy: 1'b0, cnt: '0,
                      sout: 1'b1, rxact: 1'b0, sck_prv: 1'b1};
        end else begin
            st_q <= st_d;
        end
    end

    assign rd_data  = st_q.rdr;
    assign tx_empty = ~st_q.tdr_full;
    assign rx_full  = st_q.rx_full;
    assign overrun  = st_q.ovr;
    assign irq_tx   = tx_ie & ~st_q.tdr_full;
    assign irq_rx   = rx_ie & st_q.rx_full;
    assign sck_out  = cg_sck;
    assign sck_oe   = use_int;
    assign sout     = st_q.sout;
    assign sout_oe  = sout_en;

    // R3: data line at mark level outside a transfer
    p_sout_mark_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !st_q.busy |-> st_q.sout);

    // R6: an internal start with transmit on empties the holding register
    p_tx_empty_after_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (start_int && tx_en && !wr_en) |=> tx_empty);

    // R8: overrun leaves the unread byte in place
    p_overrun_keeps_byte_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.ovr) |-> $stable(st_q.rdr));

    // R1: a transfer ends only after the last data bit
    p_byte_length_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(st_q.busy) |-> $past(st_q.cnt) == CW'(DW - 1));

    // R7: a read with no completion in the same cycle clears ready
    p_read_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !done) |=> !rx_full);

endmodule

// File: tb/sim_sync_shift_port.sv
`timescale 1ns/1ps
module sim_sync_shift_port;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 0, int_clk = 0, tx_en = 0, rx_en = 0, sout_en = 1;
    logic       tx_ie = 0, rx_ie = 0, clr_err_n = 1, wr_en = 0, rd_en = 0;
    logic [7:0] wr_data = 0;
    logic [7:0] rd_data;
    logic       tx_empty, rx_full, overrun, irq_tx, irq_rx;
    logic       sin, sck_in = 1, sck_out, sck_oe, sout, sout_oe;
    logic       loop = 1, m_sin = 1;

    int checks = 0, fails = 0, cyc = 0;
    logic [7:0] m_rdr = 0, m_tdr = 0;
    logic       m_full = 0, m_ovr = 0, m_tdr_full = 0;
    int         mon_falls;
    logic       mon_prev, mon_sout_low;

    always #2.5 clk = ~clk;

    assign sin = loop ? (sout_oe ? sout : 1'b1) : m_sin;

    sync_shift_port u0 (
        .clk(clk), .rst_n(rst_n), .tick(tick), .int_clk(int_clk),
        .tx_en(tx_en), .rx_en(rx_en), .sout_en(sout_en), .tx_ie(tx_ie),
        .rx_ie(rx_ie), .clr_err_n(clr_err_n), .wr_en(wr_en), .wr_data(wr_data),
        .rd_en(rd_en), .rd_data(rd_data), .tx_empty(tx_empty), .rx_full(rx_full),
        .overrun(overrun), .irq_tx(irq_tx), .irq_rx(irq_rx), .sin(sin),
        .sck_in(sck_in), .sck_out(sck_out), .sck_oe(sck_oe), .sout(sout),
        .sout_oe(sout_oe)
    );

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc == 150000) begin
            checks++; fails++;
            $display("FAIL watchdog: actual running expected finished");
            summary();
            $finish;
        end
    end

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] int_rx(logic [7:0] b, logic te, logic oe);
        return (oe && te) ? b : 8'hFF;
    endfunction

    function automatic logic [7:0] ext_tx(logic te, logic pend, logic [7:0] b);
        return (te && pend) ? b : 8'hFF;
    endfunction

    task automatic complete(logic [7:0] rxb);
        if (rx_en) begin
            if (m_full) m_ovr = 1'b1;
            else begin m_rdr = rxb; m_full = 1'b1; end
        end
    endtask

    task automatic status(string ctx);
        chk({"R7 rd_data ", ctx}, rd_data, m_rdr);
        chk({"R7 rx_full ", ctx}, rx_full, m_full);
        chk({"R8 overrun ", ctx}, overrun, m_ovr);
        chk({"R6 tx_empty ", ctx}, tx_empty, !m_tdr_full);
        chk({"R10 irq_rx ", ctx}, irq_rx, rx_ie & m_full);
        chk({"R10 irq_tx ", ctx}, irq_tx, tx_ie & !m_tdr_full);
        chk({"R11 sout_oe ", ctx}, sout_oe, sout_en);
    endtask

    task automatic host_write(logic [7:0] b);
        @(negedge clk); wr_en = 1; wr_data = b;
        @(negedge clk); wr_en = 0;
        m_tdr = b; m_tdr_full = 1'b1;
    endtask

    task automatic host_read();
        @(negedge clk);
        chk("R7 read value", rd_data, m_rdr);
        rd_en = 1;
        @(negedge clk); rd_en = 0;
        m_full = 1'b0;
        chk("R7 cleared by read", rx_full, 1'b0);
    endtask

    task automatic clear_err();
        @(negedge clk); clr_err_n = 0;
        @(negedge clk); clr_err_n = 1;
        m_ovr = 1'b0;
        chk("R9 overrun cleared", overrun, 1'b0);
    endtask

    task automatic mon();
        if (mon_prev && !sck_out) mon_falls++;
        mon_prev = sck_out;
        if (!sout) mon_sout_low = 1'b1;
    endtask

    // internal-clock transfer with sout looped back to sin
    task automatic int_xfer(logic [7:0] b, bit rd_at_end);
        logic [7:0] rxb;
        loop = 1;
        rxb  = int_rx(b, tx_en, sout_en);
        host_write(b);
        chk("R6 pending byte", tx_empty, 1'b0);
        @(negedge clk);
        chk("R4 byte consumed", tx_empty, 1'b1);
        m_tdr_full = 1'b0;
        mon_falls = 0; mon_prev = sck_out; mon_sout_low = 1'b0;
        for (int k = 0; k < 16; k++) begin
            for (int w = 0; w < 7; w++) begin @(negedge clk); mon(); end
            tick = 1;
            if (k == 15 && rd_at_end) rd_en = 1;
            @(negedge clk); tick = 0; rd_en = 0; mon();
        end
        repeat (4) begin @(negedge clk); mon(); end
        chk("R2 pulse count", mon_falls, 8);
        chk("R3 sck back high", sck_out, 1'b1);
        chk("R3 sout back high", sout, 1'b1);
        chk("R2 sck driven", sck_oe, 1'b1);
        if (!tx_en) chk("R4 sout held high", mon_sout_low, 1'b0);
        if (rd_at_end && rx_en) begin
            m_rdr = rxb; m_full = 1'b1;
        end else begin
            complete(rxb);
        end
    endtask

    // external-clock transfer, bench acts as clock master
    task automatic ext_xfer(logic [7:0] mosi);
        logic [7:0] got, exp;
        loop = 0;
        exp  = ext_tx(tx_en, m_tdr_full, m_tdr);
        chk("R3 sout high before", sout, 1'b1);
        chk("R5 no clock drive", sck_oe, 1'b0);
        for (int i = 0; i < 8; i++) begin
            @(negedge clk); sck_in = 0; m_sin = mosi[i];
            repeat (10) @(negedge clk);
            got[i] = sout;
            sck_in = 1;
            repeat (10) @(negedge clk);
        end
        repeat (4) @(negedge clk);
        if (tx_en && m_tdr_full) begin
            chk("R1 lsb-first byte out", got, exp);
            m_tdr_full = 1'b0;
        end else begin
            chk("R5 mark held", got, 8'hFF);
        end
        chk("R3 sout high after", sout, 1'b1);
        complete(mosi);
    endtask

    initial begin
        logic [31:0] r;
        r = $urandom(32'h5EED);
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        status("reset");
        chk("R3 reset sout", sout, 1'b1);
        chk("R3 reset sck", sck_out, 1'b1);

        // internal, full duplex loopback
        int_clk = 1; tx_en = 1; rx_en = 1; sout_en = 1;
        int_xfer(8'hA5, 0);
        status("int A5");
        host_read();

        // external, LSB first both ways
        @(negedge clk); int_clk = 0;
        host_write(8'h3C);
        ext_xfer(8'hC3);
        status("ext 3C/C3");

        // external, nothing pending: mark level
        ext_xfer(8'h81);
        status("ext empty R5");

        // external, tx off with a pending byte; rx_full still set -> overrun
        tx_en = 0;
        host_write(8'h5A);
        ext_xfer(8'h0F);
        status("ext tx off R8");
        chk("R6 byte kept while tx off", tx_empty, 1'b0);
        clear_err();
        host_read();
        tx_en = 1;
        ext_xfer(8'h96);
        status("ext pending sent R6");
        host_read();

        // receive disabled leaves the receive side untouched
        rx_en = 0;
        host_write(8'h11);
        ext_xfer(8'hEE);
        status("rx off R12");
        chk("R12 rx_full unchanged", rx_full, 1'b0);
        rx_en = 1;

        // coincident read and completion (R8)
        @(negedge clk); int_clk = 1;
        int_xfer(8'h42, 0);
        int_xfer(8'h24, 1);
        status("coincide R8");
        chk("R8 no overrun on coincidence", overrun, 1'b0);
        int_xfer(8'h99, 0);
        status("overrun R8");
        chk("R8 old byte kept", rd_data, 8'h24);
        clear_err();
        host_read();

        // receive only, internal clock (R4) and released output (R11)
        tx_en = 0;
        int_xfer(8'h77, 0);
        status("int rx only R4");
        host_read();
        tx_en = 1; sout_en = 0;
        int_xfer(8'h12, 0);
        status("sout released R11");
        host_read();
        sout_en = 1;

        // interrupt gating (R10)
        tx_ie = 1; rx_ie = 1;
        int_xfer(8'h3E, 0);
        status("irq R10");

        // constrained random
        for (int n = 0; n < 40; n++) begin
            logic [7:0] b;
            logic mode;
            b    = 8'($urandom);
            mode = 1'($urandom);
            @(negedge clk);
            tx_ie = 1'($urandom); rx_ie = 1'($urandom);
            sout_en = ($urandom % 4) != 0;
            case ($urandom % 3)
                0: begin tx_en = 1; rx_en = 1; end
                1: begin tx_en = 1; rx_en = 0; end
                default: begin tx_en = 0; rx_en = 1; end
            endcase
            if (($urandom % 2) == 0 && m_full) host_read();
            if (($urandom % 4) == 0) clear_err();
            @(negedge clk); int_clk = mode;
            if (mode) begin
                int_xfer(b, 0);
            end else begin
                if (tx_en && ($urandom % 2)) host_write(8'($urandom));
                ext_xfer(b);
            end
            status("random");
        end

        summary();
        $finish;
    end

endmodule